// File: doc/BRIEF.md
# Multi-operand carry-save adder tree

This combinational block adds a parameterized number `N` of `W`-bit operands into one `W`-bit result. A parameter mask gives each operand a sign. A set bit subtracts that operand and a clear bit adds it. An optional compile-time constant can be included as one more operand. The result is the exact signed sum taken modulo 2^W. Any carry out of the top bit is dropped.

Internally, a subtracted operand enters the tree bitwise inverted. Its +1 correction goes into a bit position that is known to be zero: the LSB of a shifted carry vector, or the carry-in of the final adder. The operand vectors, including the constant, are reduced by 3:2 compressor rows. There are exactly M-2 rows for M vectors, and each row turns three vectors into a sum vector and a carry vector shifted left by one bit. A single carry-propagate adder then combines the two vectors that remain. When every operand is subtracted and there is no constant, one correction slot is missing. In that case a zero vector is added as the constant so that the slot count stays sufficient.

The data path uses a valid/ready pair but stores nothing. A result is offered on the same cycle that its operands are offered, and `out_valid` follows `in_valid`. Back-pressure passes straight through: `in_ready` equals `out_ready`. While `in_ready` is low, the upstream side must hold `in_ops` steady, and `out_sum` then stays steady as well.

Top module: `csa_sum_tree`

## Requirements
- R1: `out_sum` equals the sum of all operands, each with its sign, plus the constant term, modulo 2^W. Operand i occupies bits `[i*W +: W]` of `in_ops`.
- R2: The result is exactly W bits wide. A sum that exceeds 2^W-1 or falls below zero wraps modulo 2^W, for example when every operand holds its maximum value.
- R3: Bit i of `SUB_MASK` set to 1 subtracts operand i, and 0 adds it. Additions and subtractions may be mixed freely within one sum.
- R4: When `CONST_EN` is 1, `CONST_VAL` is added as one more operand of the tree. When `CONST_EN` is 0, no constant is added.
- R5: With every operand subtracted and `CONST_EN` = 0, the result is still the negated sum modulo 2^W.
- R6: Every compressor row preserves the weighted total: sum vector + shifted carry vector = x + y + z + injected correction, modulo 2^W. The two vectors that reach the final adder, plus its carry-in, equal the total of all tree leaves plus the number of subtracted operands.
- R7: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in every cycle, so a transfer on the input side happens exactly when one happens on the output side.
- R8: With all operands zero, `out_sum` equals the constant term (`CONST_VAL` when enabled, otherwise 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Operand set on `in_ops` is valid |
| in_ready | output | 1 | Block can accept the operand set (equals `out_ready`) |
| in_ops | input | N*W | Packed operands, operand i at bits `[i*W +: W]` |
| out_valid | output | 1 | `out_sum` is valid (equals `in_valid`) |
| out_ready | input | 1 | Downstream accepts `out_sum` |
| out_sum | output | W | Signed sum modulo 2^W |

## Verification
Four properties are checked by the assertions whenever the inputs change:
- each compressor row keeps the weighted total of its three inputs and its injected bit;
- the tree as a whole keeps the total of its leaves plus the subtraction corrections;
- the final result matches a behavioural signed sum;
- the input and output handshakes transfer together.

What only the bench scenarios can show is that the chosen parameters give correct results across configurations: a mixed-sign sum with a constant, an all-subtracted sum where the zero constant is added, and a minimal one-row tree. They also cover the wrap-around cases with all-ones, signed-maximum and all-zero operands, and random back-pressure on the handshake.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // population count of a mask of up to 64 bits, used at elaboration
  function automatic int mask_ones(input logic [63:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) n++;
    end
    return n;
  endfunction

  // vectors in the tree: N operands plus the constant when it is needed
  function automatic int leaf_count(input int n, input int k, input bit const_en);
    bit need_const;
    need_const = const_en || (k > n - 1);
    return need_const ? n + 1 : n;
  endfunction

endpackage

// File: rtl/csa_sign_sel.sv
module csa_sign_sel #(
  parameter int          W        = 12,
  parameter int          N        = 5,
  parameter logic [N-1:0] SUB_MASK = '0
) (
  input  logic [N*W-1:0] raw_ops,
  output logic [N*W-1:0] tree_ops
);

  for (genvar i = 0; i < N; i++) begin : g_op
    if (SUB_MASK[i]) begin : g_neg
      // inverted here; the +1 is injected inside the tree
      assign tree_ops[i*W +: W] = ~raw_ops[i*W +: W];
    end else begin : g_pos
      assign tree_ops[i*W +: W] = raw_ops[i*W +: W];
    end
  end

endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W = 12
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  input  logic         inj,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);

  assign s    = x ^ y ^ z;
  assign c[0] = inj;

  // majority of the top bit would shift out, so it is not built
  for (genvar b = 0; b < W - 1; b++) begin : g_maj
    assign c[b+1] = (x[b] & y[b]) | (x[b] & z[b]) | (y[b] & z[b]);
  end

  logic [W-1:0] in_total;
  logic [W-1:0] out_total;
  always_comb begin
    in_total  = x + y + z + {{(W-1){1'b0}}, inj};
    out_total = s + c;
    // R6: a row keeps the weighted total of its inputs
    a_r6_row_conserves: assert (in_total == out_total)
      else $error("row total %0h != %0h", out_total, in_total);
  end

endmodule

// File: rtl/csa_tree.sv
module csa_tree #(
  parameter int W = 12,
  parameter int M = 6,
  parameter int K = 1
) (
  input  logic [M*W-1:0] leaves,
  output logic [W-1:0]   vec_a,
  output logic [W-1:0]   vec_b,
  output logic           cin
);

  localparam int ROWS = M - 2;
  localparam int POOL = 3 * M - 4;

  // pool of vectors used first in, first out: row r reads slots 3r..3r+2
  // and writes slots M+2r and M+2r+1, which gives a tree of log depth
  logic [POOL-1:0][W-1:0] pool;

  for (genvar i = 0; i < M; i++) begin : g_leaf
    assign pool[i] = leaves[i*W +: W];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    csa_row #(.W(W)) u_row (
      .x  (pool[3*r]),
      .y  (pool[3*r+1]),
      .z  (pool[3*r+2]),
      .inj(r < K),
      .s  (pool[M+2*r]),
      .c  (pool[M+2*r+1])
    );
  end

  assign vec_a = pool[3*M-6];
  assign vec_b = pool[3*M-5];
  assign cin   = (K > ROWS);

  logic [W-1:0] leaf_total;
  logic [W-1:0] end_total;
  always_comb begin
    leaf_total = W'(K);
    for (int i = 0; i < M; i++) begin
      leaf_total = leaf_total + leaves[i*W +: W];
    end
    end_total = vec_a + vec_b + {{(W-1){1'b0}}, cin};
    // R6: the reduction as a whole loses nothing
    a_r6_tree_conserves: assert (leaf_total == end_total)
      else $error("tree total %0h != %0h", end_total, leaf_total);
  end

endmodule

// File: rtl/csa_cpa.sv
module csa_cpa #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);

  logic [W:0] full;
  logic       unused_carry;

  assign full         = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum          = full[W-1:0];
  assign unused_carry = full[W];

endmodule

// File: rtl/csa_sum_tree.sv
module csa_sum_tree
  import csa_pkg::*;
#(
  parameter int           W         = 12,
  parameter int           N         = 5,
  parameter logic [N-1:0] SUB_MASK  = 5'b00100,
  parameter bit           CONST_EN  = 1'b1,
  parameter logic [W-1:0] CONST_VAL = 42
) (
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N*W-1:0] in_ops,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_sum
);

  localparam int K = mask_ones(64'(SUB_MASK));
  localparam int M = leaf_count(N, K, CONST_EN);
  localparam logic [W-1:0] CVEC = CONST_EN ? CONST_VAL : '0;

  logic [N*W-1:0] tree_ops;
  logic [M*W-1:0] leaves;
  logic [W-1:0]   vec_a;
  logic [W-1:0]   vec_b;
  logic           cin;

  csa_sign_sel #(.W(W), .N(N), .SUB_MASK(SUB_MASK)) u_sign (
    .raw_ops (in_ops),
    .tree_ops(tree_ops)
  );

  if (M > N) begin : g_const
    assign leaves = {CVEC, tree_ops};
  end else begin : g_noconst
    assign leaves = tree_ops;
  end

  csa_tree #(.W(W), .M(M), .K(K)) u_tree (
    .leaves(leaves),
    .vec_a (vec_a),
    .vec_b (vec_b),
    .cin   (cin)
  );

  csa_cpa #(.W(W)) u_cpa (
    .a  (vec_a),
    .b  (vec_b),
    .cin(cin),
    .sum(out_sum)
  );

  // no storage: the handshake passes straight through
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  logic [W-1:0] model_sum;
  always_comb begin
    model_sum = CVEC;
    for (int i = 0; i < N; i++) begin
      if (SUB_MASK[i]) model_sum = model_sum - in_ops[i*W +: W];
      else             model_sum = model_sum + in_ops[i*W +: W];
    end
    // R1: result is the signed sum modulo 2^W
    a_r1_signed_sum: assert (out_sum == model_sum)
      else $error("sum %0h != %0h", out_sum, model_sum);
    // R7: input and output transfers coincide
    a_r7_transfer_pair: assert ((out_valid && out_ready) == (in_valid && in_ready))
      else $error("handshake transfers differ");
  end

endmodule

// File: tb/sim_csa_sum_tree.sv
module sim_csa_sum_tree;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // u0: 5 x 12 bit, a+b-c+d+e+42
  logic        v0, r0, ov0, or0;
  logic [59:0] ops0;
  logic [11:0] sum0;
  // u1: 4 x 8 bit, all subtracted, no constant
  logic        r1, ov1;
  logic [31:0] ops1;
  logic [7:0]  sum1;
  // u2: 3 x 8 bit, all added, no constant (single row)
  logic        r2, ov2;
  logic [23:0] ops2;
  logic [7:0]  sum2;

  csa_sum_tree u0 (
    .in_valid(v0), .in_ready(r0), .in_ops(ops0),
    .out_valid(ov0), .out_ready(or0), .out_sum(sum0)
  );

  csa_sum_tree #(.W(8), .N(4), .SUB_MASK(4'b1111), .CONST_EN(1'b0), .CONST_VAL(8'd0)) u1 (
    .in_valid(1'b1), .in_ready(r1), .in_ops(ops1),
    .out_valid(ov1), .out_ready(1'b1), .out_sum(sum1)
  );

  csa_sum_tree #(.W(8), .N(3), .SUB_MASK(3'b000), .CONST_EN(1'b0), .CONST_VAL(8'd0)) u2 (
    .in_valid(1'b1), .in_ready(r2), .in_ops(ops2),
    .out_valid(ov2), .out_ready(1'b1), .out_sum(sum2)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: signed integer sum, then wrap to w bits
  function automatic longint ref_sum(input logic [63:0] ops, input int n, input int w,
                                     input int mask, input longint cval);
    longint acc;
    longint op;
    acc = cval;
    for (int i = 0; i < n; i++) begin
      op = longint'((ops >> (i * w)) & ((64'd1 << w) - 1));
      if (((mask >> i) & 1) != 0) acc = acc - op;
      else                        acc = acc + op;
    end
    return acc & ((longint'(1) << w) - 1);
  endfunction

  // fill every operand of every instance with one value
  task automatic fill_all(input logic [11:0] v);
    for (int i = 0; i < 5; i++) ops0[i*12 +: 12] = v;
    for (int i = 0; i < 4; i++) ops1[i*8 +: 8] = v[7:0];
    for (int i = 0; i < 3; i++) ops2[i*8 +: 8] = v[7:0];
  endtask

  task automatic fill_rand();
    ops0 = {$urandom, $urandom};
    ops1 = $urandom;
    ops2 = 24'($urandom);
  endtask

  task automatic check_all(input string tag);
    // R7: handshake passes through on every cycle
    check({"R7 valid ", tag}, longint'(ov0), longint'(v0));
    check({"R7 ready ", tag}, longint'(r0), longint'(or0));
    if (ov0) check({"R1 R3 R4 u0 ", tag}, longint'(sum0), ref_sum(64'(ops0), 5, 12, 5'b00100, 42));
    check({"R5 u1 ", tag}, longint'(sum1), ref_sum(64'(ops1), 4, 8, 4'b1111, 0));
    // R6: u2 is one compressor row feeding the adder
    check({"R6 u2 ", tag}, longint'(sum2), ref_sum(64'(ops2), 3, 8, 0, 0));
  endtask

  initial begin
    v0 = 1'b0; or0 = 1'b0;
    fill_all(12'h000);
    #1;
    // reset state: nothing offered, nothing valid
    check("R7 reset valid", longint'(ov0), 0);
    check("R7 reset ready", longint'(r0), 0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R8: all zero gives the constant term
    @(posedge clk); #1;
    v0 = 1'b1; or0 = 1'b1; fill_all(12'h000);
    @(negedge clk);
    check("R8 zero u0", longint'(sum0), 42);
    check("R8 zero u1", longint'(sum1), 0);
    check("R8 zero u2", longint'(sum2), 0);

    // R2: all ones / max on every operand wraps
    @(posedge clk); #1;
    fill_all(12'hFFF);
    @(negedge clk);
    check("R2 max u0", longint'(sum0), 39);  // 3*4095+42 mod 4096
    check("R2 max u1", longint'(sum1), 4);   // -4*255 mod 256
    check("R2 max u2", longint'(sum2), 253); // 3*255 mod 256
    check_all("max");

    // signed maximum pattern
    @(posedge clk); #1;
    fill_all(12'h7FF);
    @(negedge clk);
    check_all("smax");

    // R3: only the subtracted operand non-zero
    @(posedge clk); #1;
    fill_all(12'h000);
    ops0[2*12 +: 12] = 12'd1;
    @(negedge clk);
    check("R3 sub only", longint'(sum0), 41);

    // R4: a+b+d+e with c zero includes the constant
    @(posedge clk); #1;
    ops0 = '0;
    ops0[0 +: 12] = 12'd100;
    ops0[12 +: 12] = 12'd200;
    @(negedge clk);
    check("R4 const add", longint'(sum0), 342);

    // random stream with random back-pressure
    for (int n = 0; n < 400; n++) begin
      @(posedge clk); #1;
      fill_rand();
      v0 = 1'($urandom);
      or0 = 1'($urandom);
      @(negedge clk);
      check_all("rand");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule